// File: doc/BRIEF.md
# Two-Level Page Walker with Access Tracking

This block turns a 32-bit virtual address into a physical page frame by fetching a directory entry and, for small pages, a table entry from memory. A caller presents the address together with the kind of access (read or write, user or supervisor), the supervisor write-protect control, the large-page enable, the directory root base and an address mask. The walker then runs its memory reads and any needed write-backs over a single request/acknowledge port.

A walk ends in one of two ways. It can succeed, giving the frame number and the read, write and execute rights. It can fail, giving a 3-bit error code and the faulting virtual address. On the way the walker marks entries as accessed, and as dirty on writes. It writes an entry back only when one of those bits actually changes. Write permission is given only for a page that is already dirty, so the first write to a clean page always goes through a walk that marks it.

Entry bit positions used throughout: present = bit 0, writable = bit 1, user = bit 2, accessed = bit 5, dirty = bit 6, large page = bit 7. Error code bits: bit 0 = protection violation (clear for a not-present entry), bit 1 = write access, bit 2 = user access.

Top module: `pt_walker`

## Requirements
- R1: The directory entry is read from ((root_base with bits 11:0 cleared) + va[31:22]*4) AND addr_mask.
- R2: For a small page, the table entry is read from ((directory entry with bits 11:0 cleared) + va[21:12]*4) AND addr_mask.
- R3: A directory or table entry with bit 0 clear ends the walk in a fault whose error code bit 0 is clear. No entry is written back in that case.
- R4: A directory entry with bit 7 set is a 4 MB leaf only when large_en is 1. Its frame is entry bits 31:22 joined with va[21:12], and no table entry is read. When large_en is 0, bit 7 is ignored and the table is walked.
- R5: For a small page, the effective user and writable rights are the bitwise AND of the directory and table entries.
- R6: A user access faults when the effective user bit is clear, or when it is a write and the effective writable bit is clear. A supervisor write faults on a clear writable bit only when wp_en is 1. Any such fault sets error code bit 0.
- R7: The leaf entry gets bit 5 set, plus bit 6 on a write, and it is written back only if its value changes. A directory entry pointing to a table gets only bit 5 set, written back before the table read and only if bit 5 was clear.
- R8: A fault pulses fault_valid for one cycle with fault_code = {user, write, protection}. fault_addr takes the virtual address and holds it until the next fault.
- R9: A successful walk pulses done_valid for one cycle. perm_r and perm_x are 1. perm_w is 1 only if the final leaf entry is dirty and the access is not write-protected: for a user access the effective writable bit must be set; for a supervisor access the effective writable bit must be set or wp_en must be 0.
- R10: mem_req, mem_we, mem_addr and mem_wdata hold steady until mem_ack. A new request is taken only while req_ready is high, and req_valid is ignored during a walk.
- R11: page_frame is the 20-bit frame number after addr_mask is applied to the leaf entry's frame bits. The in-page offset bits of a large page are not masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken when req_ready) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| wp_en | input | 1 | Supervisor writes honour the writable bit |
| large_en | input | 1 | Enables 4 MB directory leaves |
| root_base | input | 32 | Directory base address |
| addr_mask | input | 32 | Mask applied to every entry address and frame |
| req_ready | output | 1 | Walker idle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Updated entry to store |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Entry read data, valid with mem_ack |
| done_valid | output | 1 | One-cycle pulse: translation ready |
| page_frame | output | 20 | Physical 4 KB frame number |
| perm_r | output | 1 | Read allowed |
| perm_w | output | 1 | Write allowed |
| perm_x | output | 1 | Execute allowed |
| fault_valid | output | 1 | One-cycle pulse: page fault |
| fault_code | output | 3 | {user, write, protection} |
| fault_addr | output | 32 | Virtual address of the last fault |

## Verification
The hardest cases to reach are those where rights are split across two entries, since a fault can arise from the AND of directory and table bits even though each entry alone would allow the access. Such cases also have to be separated from the right order of write-backs. The bench keeps a sparse memory model that it loads with hand-chosen entry pairs. It checks the final contents of both entry slots, not only the walk result, so a missing, extra or misordered write-back is visible at the ports. A varying acknowledge delay and a stray request raised mid-walk exercise the hold and ignore rules.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic        req_user,
  input  logic        wp_en,
  input  logic        large_en,
  input  logic [31:0] root_base,
  input  logic [31:0] addr_mask,
  output logic        req_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        done_valid,
  output logic [19:0] page_frame,
  output logic        perm_r,
  output logic        perm_w,
  output logic        perm_x,
  output logic        fault_valid,
  output logic [2:0]  fault_code,
  output logic [31:0] fault_addr
);
  localparam int P_B = 0, RW_B = 1, US_B = 2, A_B = 5, D_B = 6, PS_B = 7;

  typedef enum logic [2:0] {S_IDLE, S_RD_DIR, S_WB_DIR, S_RD_TBL, S_WB_LEAF, S_DONE, S_FAULT} st_t;
  st_t st;

  logic [31:0] va, base, mask, dir_e, leaf, leaf_addr, flt_va;
  logic        is_wr, is_usr, wp, lg_en, big, eff_rw_q;
  logic [2:0]  code_q;

  logic [31:0] dir_addr, tbl_addr, upd;
  logic        eff_us, eff_rw, deny, take_big;

  assign dir_addr = ((base & 32'hFFFF_F000) + {20'b0, va[31:22], 2'b00}) & mask;
  assign tbl_addr = ((dir_e & 32'hFFFF_F000) + {20'b0, va[21:12], 2'b00}) & mask;
  assign eff_us   = (st == S_RD_TBL) ? (mem_rdata[US_B] & dir_e[US_B]) : mem_rdata[US_B];
  assign eff_rw   = (st == S_RD_TBL) ? (mem_rdata[RW_B] & dir_e[RW_B]) : mem_rdata[RW_B];
  assign deny     = is_usr ? (!eff_us || (is_wr && !eff_rw)) : (wp && is_wr && !eff_rw);
  assign upd      = mem_rdata | (32'b1 << A_B) | ({31'b0, is_wr} << D_B);
  assign take_big = mem_rdata[PS_B] && lg_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      va <= '0; base <= '0; mask <= '0; dir_e <= '0; leaf <= '0; leaf_addr <= '0;
      flt_va <= '0; is_wr <= 1'b0; is_usr <= 1'b0; wp <= 1'b0; lg_en <= 1'b0;
      big <= 1'b0; eff_rw_q <= 1'b0; code_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va <= req_vaddr; is_wr <= req_write; is_usr <= req_user;
          wp <= wp_en; lg_en <= large_en; base <= root_base; mask <= addr_mask;
          st <= S_RD_DIR;
        end
        S_RD_DIR, S_RD_TBL: if (mem_ack) begin
          if (st == S_RD_DIR) dir_e <= mem_rdata;
          if (!mem_rdata[P_B]) begin
            code_q <= {is_usr, is_wr, 1'b0}; flt_va <= va; st <= S_FAULT;
          end else if (st == S_RD_DIR && !take_big) begin
            st <= mem_rdata[A_B] ? S_RD_TBL : S_WB_DIR;
          end else if (deny) begin
            code_q <= {is_usr, is_wr, 1'b1}; flt_va <= va; st <= S_FAULT;
          end else begin
            leaf      <= upd;
            leaf_addr <= (st == S_RD_DIR) ? dir_addr : tbl_addr;
            big       <= (st == S_RD_DIR);
            eff_rw_q  <= eff_rw;
            st        <= (upd != mem_rdata) ? S_WB_LEAF : S_DONE;
          end
        end
        S_WB_DIR:  if (mem_ack) st <= S_RD_TBL;
        S_WB_LEAF: if (mem_ack) st <= S_DONE;
        default:   st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      S_RD_DIR:  mem_addr = dir_addr;
      S_WB_DIR:  begin mem_addr = dir_addr; mem_wdata = dir_e | (32'b1 << A_B); end
      S_RD_TBL:  mem_addr = tbl_addr;
      S_WB_LEAF: begin mem_addr = leaf_addr; mem_wdata = leaf; end
      default:   ;
    endcase
  end

  assign req_ready   = (st == S_IDLE);
  assign mem_req     = (st == S_RD_DIR) || (st == S_WB_DIR) || (st == S_RD_TBL) || (st == S_WB_LEAF);
  assign mem_we      = (st == S_WB_DIR) || (st == S_WB_LEAF);
  assign done_valid  = (st == S_DONE);
  assign fault_valid = (st == S_FAULT);
  assign fault_code  = code_q;
  assign fault_addr  = flt_va;
  assign perm_r      = 1'b1;
  assign perm_x      = 1'b1;
  assign perm_w      = leaf[D_B] && (is_usr ? eff_rw_q : (!wp || eff_rw_q));
  assign page_frame  = big ? {leaf[31:22] & mask[31:22], va[21:12]} : (leaf[31:12] & mask[31:12]);

  // R10: a pending memory request holds its command until acknowledged
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R10: no memory traffic while the walker advertises it can accept work
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  // R7: every write-back carries the accessed bit
  a_r7_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[A_B]);

  // R3: only present entries are ever written back
  a_r3_wb_present: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[P_B]);

  // R8: fault_addr changes only as a fault is reported
  a_r8_faddr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_valid |=> $stable(fault_addr) || fault_valid);

  // R9: a result is a single pulse followed by idle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> req_ready && !done_valid);
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, req_valid, req_write, req_user, wp_en, large_en, mem_ack;
  logic [31:0] req_vaddr, root_base, addr_mask, mem_rdata;
  logic        req_ready, mem_req, mem_we, done_valid, perm_r, perm_w, perm_x, fault_valid;
  logic [31:0] mem_addr, mem_wdata, fault_addr;
  logic [19:0] page_frame;
  logic [2:0]  fault_code;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .wp_en(wp_en), .large_en(large_en),
    .root_base(root_base), .addr_mask(addr_mask), .req_ready(req_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done_valid(done_valid),
    .page_frame(page_frame), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x),
    .fault_valid(fault_valid), .fault_code(fault_code), .fault_addr(fault_addr));

  int nchk = 0, nfail = 0, nwr = 0, stall_len = 0;
  bit finished = 0;
  logic [31:0] mem [logic [31:0]];

  initial begin
    mem_ack = 1'b0; mem_rdata = '0;
    forever begin
      int cnt;
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0; cnt = 0;
      end else if (mem_req) begin
        if (cnt < stall_len) cnt++;
        else begin
          cnt = 0; mem_ack = 1'b1;
          if (mem_we) begin mem[mem_addr] = mem_wdata; nwr++; end
          else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  logic r_done, r_fault, r_pw, r_pr, r_px;
  logic [2:0] r_code;
  logic [19:0] r_frame;
  logic [31:0] r_faddr;

  task automatic walk(input logic [31:0] va, input logic wr, input logic usr, input logic wp,
                      input logic lg, input logic [31:0] base, input logic [31:0] msk);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_vaddr = va; req_write = wr; req_user = usr; wp_en = wp; large_en = lg;
    root_base = base; addr_mask = msk; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    r_done = 0; r_fault = 0;
    for (int i = 0; i < 200; i++) begin
      if (done_valid || fault_valid) begin
        r_done = done_valid; r_fault = fault_valid; r_code = fault_code;
        r_faddr = fault_addr; r_frame = page_frame; r_pw = perm_w; r_pr = perm_r; r_px = perm_x;
        break;
      end
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [31:0] pde, pte;
    logic wr, usr, wp, lg;
    logic flt;
    logic [2:0] code;
    logic [19:0] frame;
    logic pw;
    logic [1:0] nw;
    logic [31:0] pde_end, pte_end;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{32'h00002027, 32'h00005067, 1'b0,1'b0,1'b1,1'b0, 1'b0,3'd0,20'h00005,1'b1,2'd0, 32'h00002027,32'h00005067},
    '{32'h00002007, 32'h00005007, 1'b0,1'b1,1'b1,1'b0, 1'b0,3'd0,20'h00005,1'b0,2'd2, 32'h00002027,32'h00005027},
    '{32'h00002027, 32'h00005027, 1'b1,1'b1,1'b1,1'b0, 1'b0,3'd0,20'h00005,1'b1,2'd1, 32'h00002027,32'h00005067},
    '{32'h00002023, 32'h00005067, 1'b0,1'b1,1'b1,1'b0, 1'b1,3'd5,20'h00000,1'b0,2'd0, 32'h00002023,32'h00005067},
    '{32'h00002027, 32'h00005025, 1'b1,1'b1,1'b1,1'b0, 1'b1,3'd7,20'h00000,1'b0,2'd0, 32'h00002027,32'h00005025},
    '{32'h00002027, 32'h00005065, 1'b1,1'b0,1'b1,1'b0, 1'b1,3'd3,20'h00000,1'b0,2'd0, 32'h00002027,32'h00005065},
    '{32'h00002027, 32'h00005065, 1'b1,1'b0,1'b0,1'b0, 1'b0,3'd0,20'h00005,1'b1,2'd0, 32'h00002027,32'h00005065},
    '{32'h00002026, 32'h00005067, 1'b0,1'b0,1'b1,1'b0, 1'b1,3'd0,20'h00000,1'b0,2'd0, 32'h00002026,32'h00005067},
    '{32'h00002027, 32'h00005066, 1'b1,1'b1,1'b1,1'b0, 1'b1,3'd6,20'h00000,1'b0,2'd0, 32'h00002027,32'h00005066},
    '{32'h008000E7, 32'h00005067, 1'b0,1'b0,1'b1,1'b1, 1'b0,3'd0,20'h00803,1'b1,2'd0, 32'h008000E7,32'h00005067},
    '{32'h000020A7, 32'h00005067, 1'b0,1'b0,1'b1,1'b0, 1'b0,3'd0,20'h00005,1'b1,2'd0, 32'h000020A7,32'h00005067},
    '{32'h00800087, 32'h00005067, 1'b1,1'b1,1'b1,1'b1, 1'b0,3'd0,20'h00803,1'b1,2'd1, 32'h008000E7,32'h00005067},
    '{32'h00002025, 32'h00005067, 1'b1,1'b1,1'b1,1'b0, 1'b1,3'd7,20'h00000,1'b0,2'd0, 32'h00002025,32'h00005067},
    '{32'h00800085, 32'h00005067, 1'b0,1'b1,1'b1,1'b1, 1'b0,3'd0,20'h00803,1'b0,2'd1, 32'h008000A5,32'h00005067},
    '{32'h00002027, 32'h00005021, 1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,20'h00005,1'b0,2'd0, 32'h00002027,32'h00005021}
  };

  localparam logic [31:0] VA = 32'h0040_3000;

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_user = 1'b0;
    wp_en = 1'b0; large_en = 1'b0; root_base = '0; addr_mask = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset ready", {31'b0, req_ready}, 32'd1);
    chk("R10 reset no mem_req", {31'b0, mem_req}, 32'd0);
    chk("R9 reset no done", {31'b0, done_valid}, 32'd0);
    chk("R8 reset no fault", {31'b0, fault_valid}, 32'd0);
    chk("R8 reset fault_addr", fault_addr, 32'd0);
    rst_n = 1'b1;

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VECS[k];
      mem.delete();
      mem[32'h0000_1004] = v.pde;
      mem[32'h0000_200C] = v.pte;
      nwr = 0;
      stall_len = k % 3;
      walk(VA, v.wr, v.usr, v.wp, v.lg, 32'h0000_1000, 32'hFFFF_FFFF);
      chk($sformatf("R3 R6 v%0d fault flag", k), {31'b0, r_fault}, {31'b0, v.flt});
      chk($sformatf("R9 v%0d done flag", k), {31'b0, r_done}, {31'b0, !v.flt});
      if (v.flt) begin
        chk($sformatf("R8 v%0d fault code", k), {29'b0, r_code}, {29'b0, v.code});
        chk($sformatf("R8 v%0d fault addr", k), r_faddr, VA);
      end else begin
        chk($sformatf("R4 R11 v%0d frame", k), {12'b0, r_frame}, {12'b0, v.frame});
        chk($sformatf("R9 v%0d write perm", k), {31'b0, r_pw}, {31'b0, v.pw});
        chk($sformatf("R9 v%0d read/exec perm", k), {30'b0, r_pr, r_px}, 32'd3);
      end
      chk($sformatf("R7 v%0d write-back count", k), nwr, {30'b0, v.nw});
      chk($sformatf("R1 R7 v%0d directory entry", k), mem[32'h0000_1004], v.pde_end);
      chk($sformatf("R2 R7 v%0d table entry", k), mem[32'h0000_200C], v.pte_end);
    end

    // R11 R1 R2: mask clears bit 20 of entry addresses and frame
    mem.delete();
    mem[32'h0000_1004] = 32'h0010_2027;
    mem[32'h0000_200C] = 32'h0010_5067;
    nwr = 0; stall_len = 1;
    walk(VA, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0010_1000, 32'hFFEF_FFFF);
    chk("R11 masked walk done", {31'b0, r_done}, 32'd1);
    chk("R11 masked frame", {12'b0, r_frame}, 32'h0000_0005);

    // R4 R11: large page keeps va offset bit 20 unmasked
    mem.delete();
    mem[32'h0000_1004] = 32'h00C0_00E7;
    walk(32'h0050_7000, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_1000, 32'hFFEF_FFFF);
    chk("R4 R11 large frame offset", {12'b0, r_frame}, 32'h0000_0D07);

    // R10: stray request during a walk is ignored
    mem.delete();
    mem[32'h0000_1004] = 32'h0000_2027;
    mem[32'h0000_200C] = 32'h0000_5067;
    stall_len = 3;
    @(negedge clk);
    req_vaddr = VA; req_write = 1'b0; req_user = 1'b0; wp_en = 1'b1; large_en = 1'b0;
    root_base = 32'h0000_1000; addr_mask = '1; req_valid = 1'b1;
    @(negedge clk);
    req_vaddr = 32'h00C0_0000;
    repeat (3) @(negedge clk);
    chk("R10 busy not ready", {31'b0, req_ready}, 32'd0);
    req_valid = 1'b0;
    r_done = 0;
    for (int i = 0; i < 200; i++) begin
      if (done_valid) begin r_done = 1; r_frame = page_frame; break; end
      @(negedge clk);
    end
    chk("R10 first walk result", {11'b0, r_done, r_frame}, {11'b0, 1'b1, 20'h00005});
    repeat (3) begin
      @(negedge clk);
      chk("R10 no second walk", {31'b0, mem_req}, 32'd0);
    end

    finish_run();
  end
endmodule